// File: doc/BRIEF.md
# Power-good channel timeout array

This block produces one power-good flag per monitored supply rail. Each rail has an undervoltage comparator outside the block. The comparator's result arrives here already synchronous to the system clock. The block also takes a shared force input, a margin-hold input and a supply-lockout input. The force input pulls every flag low. The margin-hold input freezes every flag at its present value. The lockout input signals that the supply is below its lockout level, and it holds every flag low.

A flag drops in the cycle after its channel reports undervoltage or the force input is seen high. It is released only after a recovery delay that counts consecutive clean clock cycles. Each channel owns its own recovery counter, so rails recover independently of one another. The flags carry logical levels only. The pad drivers, the analog comparison and the threshold choice sit outside this block. The usual use is to wire each flag to the enable of a downstream regulator, which gives turn-on sequencing.

Top module: `pg_timeout_array`

## Requirements
- R1: `pg_o[c]` is 0 (asserted) in the cycle after an edge at which `uv_i[c]` is 1 and margin hold is not in effect.
- R2: After the last fault clears, `pg_o[c]` rises to 1 on the RELEASE_TICKS-th consecutive clean edge. An edge is clean for channel c when `uv_i[c]`, `force_i` and lockout are all inactive. Before that edge the flag stays 0.
- R3: An edge at which `force_i` is 1 and margin hold is not in effect sets every bit of `pg_o` to 0 after that edge. When `force_i` returns to 0, each channel that has no undervoltage of its own releases after the R2 delay.
- R4: A fault during recovery restarts that channel's count from zero, so release comes RELEASE_TICKS clean edges after the new fault clears.
- R5: `hold_ni` is active low and passes through a SYNC_STAGES-flop synchronizer. While it is in effect, every output and every recovery count is frozen. On release, each channel resumes from the count it held.
- R6: `lockout_i` is active high and passes through a SYNC_STAGES-flop synchronizer. While it is in effect, every bit of `pg_o` is 0 and every count is cleared. It takes priority over margin hold.
- R7: Each channel reacts only to its own `uv_i` bit. A fault or a recovery on one channel leaves the other flags unchanged.
- R8: While `rst_ni` is 0, every bit of `pg_o` is 0. Both synchronizers reset to "lockout in effect, hold not in effect". This means the first release comes no sooner than SYNC_STAGES+RELEASE_TICKS edges after reset is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uv_i | input | N_CH | Per-channel undervoltage, 1 = below threshold, synchronous |
| force_i | input | 1 | Shared force, 1 = drive all flags low, synchronous |
| hold_ni | input | 1 | Margin hold, 0 = freeze all flags, asynchronous |
| lockout_i | input | 1 | Supply lockout, 1 = hold all flags low, asynchronous |
| pg_o | output | N_CH | Power-good flags, 0 = asserted (not good), 1 = released |

## Verification
The assertions take `uv_i` and `force_i` to be synchronous to `clk_i`, so their values at an edge are the ones the channels act on. They judge margin hold and lockout only through their synchronized copies. For that reason the properties carry no assumption on the raw asynchronous levels. The stimulus changes every input on the falling clock edge. It keeps each level of `hold_ni` and `lockout_i` long enough to pass the synchronizer, so each expected cycle follows directly from the stated stage count.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    ST_HELD    = 2'd0,
    ST_RECOVER = 2'd1,
    ST_GOOD    = 2'd2
  } pg_state_e;

  typedef struct packed {
    logic lock;
    logic freeze;
  } pg_ctrl_t;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pg_channel.sv
module pg_channel
  import pg_pkg::*;
#(
  parameter int RELEASE_TICKS = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     fault_i,
  input  pg_ctrl_t ctrl_i,
  output logic     pg_o
);
  localparam int CNT_W = (RELEASE_TICKS > 2) ? $clog2(RELEASE_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RELEASE_TICKS - 1);

  pg_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (ctrl_i.lock) begin
      st_d  = ST_HELD;
      cnt_d = '0;
    end else if (ctrl_i.freeze) begin
      st_d  = st_q;
      cnt_d = cnt_q;
    end else if (fault_i) begin
      st_d  = ST_HELD;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_HELD: begin
          st_d  = ST_RECOVER;
          cnt_d = CNT_W'(1);
        end
        ST_RECOVER: begin
          if (cnt_q == LAST) begin
            st_d  = ST_GOOD;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: st_d = ST_GOOD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HELD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign pg_o = (st_q == ST_GOOD);
endmodule

// File: rtl/pg_timeout_array.sv
module pg_timeout_array
  import pg_pkg::*;
#(
  parameter int N_CH          = 4,
  parameter int RELEASE_TICKS = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] uv_i,
  input  logic            force_i,
  input  logic            hold_ni,
  input  logic            lockout_i,
  output logic [N_CH-1:0] pg_o
);
  logic     lock_q;
  logic     hold_n_q;
  logic     hold_act;
  pg_ctrl_t ctrl;

  // both reset to the safe side: locked out, not frozen
  pg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_lock_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lockout_i), .q_o(lock_q)
  );
  pg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hold_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hold_ni), .q_o(hold_n_q)
  );

  assign hold_act    = !hold_n_q;
  assign ctrl.lock   = lock_q;
  assign ctrl.freeze = hold_act;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pg_channel #(.RELEASE_TICKS(RELEASE_TICKS)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fault_i(uv_i[c] | force_i),
      .ctrl_i (ctrl),
      .pg_o   (pg_o[c])
    );
  end
endmodule

// File: rtl/pg_timeout_chk.sv
module pg_timeout_chk #(
  parameter int N_CH = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] uv_i,
  input logic            force_i,
  input logic            lock_q,
  input logic            hold_act,
  input logic [N_CH-1:0] pg_o
);
  AST_FORCE_ALL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && !hold_act) |=> (pg_o == '0));  // R3

  AST_LOCK_ALL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> (pg_o == '0));  // R6

  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_act && !lock_q) |=> (pg_o == $past(pg_o)));  // R5

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    AST_UV_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (uv_i[c] && !hold_act) |=> !pg_o[c]);  // R1

    AST_RISE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pg_o[c]) |-> $past(!uv_i[c] && !force_i && !lock_q && !hold_act));  // R2
  end
endmodule

bind pg_timeout_array pg_timeout_chk #(.N_CH(N_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .uv_i    (uv_i),
  .force_i (force_i),
  .lock_q  (lock_q),
  .hold_act(hold_act),
  .pg_o    (pg_o)
);

// File: tb/tb_pg_timeout_array.sv
`timescale 1ns/1ps
module tb_pg_timeout_array;
  localparam int N  = 4;
  localparam int T  = 8;

  typedef struct {
    int           cyc;
    logic [N-1:0] exp_v;
    string        tag;
  } item_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] uv_i = '0;
  logic         force_i = 1'b0;
  logic         hold_ni = 1'b1;
  logic         lockout_i = 1'b0;
  logic [N-1:0] pg_o;

  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  item_t sb_q[$];

  pg_timeout_array #(.N_CH(N), .RELEASE_TICKS(T), .SYNC_STAGES(2)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .uv_i(uv_i), .force_i(force_i),
    .hold_ni(hold_ni), .lockout_i(lockout_i), .pg_o(pg_o)
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic expect_at(input int at, input logic [N-1:0] v, input string tag);
    item_t it;
    it.cyc = at; it.exp_v = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic goto(input int k);
    while (cyc < k) @(negedge clk_i);
  endtask

  // monitor: pop items whose cycle has come and compare
  always @(negedge clk_i) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].cyc <= cyc) begin
        checks++;
        if (sb_q[i].cyc < cyc || pg_o !== sb_q[i].exp_v) begin
          failures++;
          $display("FAIL %s cyc=%0d actual=%b expected=%b", sb_q[i].tag,
                   sb_q[i].cyc, pg_o, sb_q[i].exp_v);
        end
        sb_q.delete(i);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8 reset state, lockout synchronizer starts locked
    expect_at(3, 4'b0000, "R8");
    goto(5);
    rst_ni = 1'b1;
    expect_at(7, 4'b0000, "R8");
    expect_at(14, 4'b0000, "R2");
    expect_at(15, 4'b1111, "R2");

    // R1, R7: single channel undervoltage
    goto(20); uv_i = 4'b0010;
    expect_at(21, 4'b1101, "R1");
    goto(23); uv_i = 4'b0000;
    expect_at(30, 4'b1101, "R2");
    expect_at(31, 4'b1111, "R2");

    // R4: re-fault during recovery restarts count
    goto(35); uv_i = 4'b0100;
    goto(36); uv_i = 4'b0000;
    goto(40); uv_i = 4'b0100;
    goto(41); uv_i = 4'b0000;
    expect_at(44, 4'b1011, "R4");
    expect_at(48, 4'b1011, "R4");
    expect_at(49, 4'b1111, "R4");

    // R7: independent release
    goto(55); uv_i = 4'b1001;
    goto(56); uv_i = 4'b1000;
    goto(59); uv_i = 4'b0000;
    expect_at(63, 4'b0110, "R7");
    expect_at(64, 4'b0111, "R7");
    expect_at(66, 4'b0111, "R7");
    expect_at(67, 4'b1111, "R7");

    // R3: force with one channel still under threshold
    goto(70); force_i = 1'b1; uv_i = 4'b0010;
    expect_at(71, 4'b0000, "R3");
    goto(73); force_i = 1'b0;
    expect_at(80, 4'b0000, "R3");
    expect_at(81, 4'b1101, "R3");
    goto(85); uv_i = 4'b0000;
    expect_at(92, 4'b1101, "R3");
    expect_at(93, 4'b1111, "R3");

    // R5: hold ignores a new fault until released
    goto(100); hold_ni = 1'b0;
    goto(103); uv_i = 4'b0001;
    expect_at(105, 4'b1111, "R5");
    expect_at(110, 4'b1111, "R5");
    goto(110); hold_ni = 1'b1;
    expect_at(112, 4'b1111, "R5");
    expect_at(113, 4'b1110, "R1");

    // R5: hold freezes a counting channel, count resumes
    goto(115); uv_i = 4'b0000;
    goto(118); hold_ni = 1'b0;
    goto(125); hold_ni = 1'b1;
    expect_at(127, 4'b1110, "R5");
    expect_at(129, 4'b1110, "R5");
    expect_at(130, 4'b1111, "R5");

    // R6: lockout
    goto(135); lockout_i = 1'b1;
    expect_at(137, 4'b1111, "R6");
    expect_at(138, 4'b0000, "R6");
    goto(140); lockout_i = 1'b0;
    expect_at(149, 4'b0000, "R6");
    expect_at(150, 4'b1111, "R6");

    // R6: lockout wins over hold, then hold freezes low
    goto(155); hold_ni = 1'b0; lockout_i = 1'b1;
    expect_at(158, 4'b0000, "R6");
    goto(160); lockout_i = 1'b0;
    expect_at(175, 4'b0000, "R5");
    goto(175); hold_ni = 1'b1;
    expect_at(184, 4'b0000, "R6");
    expect_at(185, 4'b1111, "R6");

    goto(190);
    while (sb_q.size() != 0) @(negedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule